// File: doc/BRIEF.md
# Programmed I/O Disk Interface Access Timer

This block is the host side of a parallel disk-style register interface on which the processor starts every transfer itself. A request carries a direction, a 3-bit device register address and, for a write, a 16-bit data word. For each accepted request the block runs exactly one bus access toward the device. It drives the address lines, one of two active-low strobes and the data bus enable. It then returns read data together with a one-clock completion pulse.

Every access has the same shape: an address setup phase, a strobe phase and a recovery phase. Seven timing modes share this signalling. They differ only in the minimum total access length, which is converted from nanoseconds to system clocks and always rounded up. The block wakes up in the slowest mode. Software moves it to a faster mode through a small mode-select port, normally after it has read the device's capabilities at the slow rate. A device ready input can stretch the strobe phase.

Top module: `pio_xfer_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `busy`, `done` and `dev_dq_oe` are low, `dev_rd_n` and `dev_wr_n` are high, and the active mode is 0.
- R2: Each accepted request (`req_valid` high while `busy` is low) produces exactly one access. A request presented while `busy` is high starts no access, and is neither stored nor replayed later.
- R3: With a 4 ns clock, the access length C in clocks is 150, 96, 60, 45, 30, 25 and 20 for modes 0 through 6. These values come from 600, 383, 240, 180, 120, 100 and 80 ns, each rounded up to whole clocks. Setup lasts S = ceil(C*20/100) clocks with both strobes high and the address valid. The strobe then stays low for W = ceil(C*50/100) clocks. Recovery lasts until the access has lasted C clocks. `dev_addr` is stable for the whole access.
- R4: A mode write takes effect at the start of the next accepted access. A write made during an access does not change that access's timing.
- R5: A mode write with value 7 is ignored, and the previous mode stays in force.
- R6: If `dev_ready` is low at the end of the last planned strobe clock, the strobe stays low until the first clock edge that sees `dev_ready` high. The access then lasts max(C, S + W' + 1) clocks, where W' is the actual strobe length.
- R7: For a read, `rdata` takes the value of `dev_dq_in` on the clock edge that releases the strobe. `done` is high for exactly the one clock after that edge, and `rdata` holds its value until the next read completes. `done` also pulses after a write.
- R8: During a write access, `dev_dq_oe` is high for exactly the setup and strobe clocks, and `dev_dq_out` equals the request's data word. During reads and while idle, `dev_dq_oe` is low.
- R9: `busy` rises in the clock after acceptance and falls after the last recovery clock. A new request is accepted as soon as `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start one access (taken only while not busy) |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 3 | Device register address |
| req_wdata | input | 16 | Write data word |
| mode_we | input | 1 | Load `mode_sel` into the mode register |
| mode_sel | input | 3 | Timing mode 0..6 (7 ignored) |
| busy | output | 1 | Access in progress; requests refused |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Last read data word |
| dev_addr | output | 3 | Address lines to device |
| dev_rd_n | output | 1 | Active-low read strobe |
| dev_wr_n | output | 1 | Active-low write strobe |
| dev_dq_out | output | 16 | Data bus value driven by host |
| dev_dq_oe | output | 1 | Data bus drive enable (low = released) |
| dev_dq_in | input | 16 | Data bus value from device |
| dev_ready | input | 1 | Device ready; low stretches the strobe |

## Verification
The bench measures the setup, strobe and total access lengths in every mode. A rounding error in the nanosecond-to-clock conversion therefore shows up as a cycle that is one clock short. It writes a new mode in the middle of a fast access: a design that applies the mode immediately stretches or cuts the access that is already running. It pokes `req_valid` while busy, which exposes a design that queues the request and runs a phantom second access. It stalls ready both below and beyond the minimum length, which catches designs that drop the strobe early or add recovery on top of an already long access. It also writes the reserved mode value, which a careless register would accept and turn into garbage timing.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 7;
  localparam int CNT_W     = 16;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] cycle;
  } pio_timing_t;

  // minimum access length per mode, nanoseconds
  function automatic int unsigned mode_cycle_ns(input int unsigned m);
    case (m)
      0:       return 600;
      1:       return 383;
      2:       return 240;
      3:       return 180;
      4:       return 120;
      5:       return 100;
      default: return 80;
    endcase
  endfunction

  // round up so that the minimum is never violated
  function automatic int unsigned ns_to_clks(input int unsigned ns,
                                             input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned pct_ceil(input int unsigned c,
                                           input int unsigned pct);
    int unsigned v;
    v = (c * pct + 99) / 100;
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/pio_mode_reg.sv
module pio_mode_reg
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_sel,
  output logic [MODE_W-1:0] mode_q
);

  logic mode_legal;
  assign mode_legal = (mode_sel < MODE_W'(NUM_MODES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_we && mode_legal) begin
      mode_q <= mode_sel;
    end
  end

endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
  import pio_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned SETUP_PCT     = 20,
  parameter int unsigned STROBE_PCT    = 50
) (
  input  logic [MODE_W-1:0] mode,
  output pio_timing_t       tim
);

  pio_timing_t tbl [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    localparam int unsigned CYC = ns_to_clks(mode_cycle_ns(g), CLK_PERIOD_PS);
    localparam int unsigned SET = pct_ceil(CYC, SETUP_PCT);
    localparam int unsigned STB = pct_ceil(CYC, STROBE_PCT);
    assign tbl[g].cycle  = CNT_W'(CYC);
    assign tbl[g].setup  = CNT_W'(SET);
    assign tbl[g].strobe = CNT_W'(STB);
  end

  always_comb begin
    tim = tbl[0];
    for (int i = 0; i < NUM_MODES; i++) begin
      if (mode == MODE_W'(i)) tim = tbl[i];
    end
  end

endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int MIN_RECOV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [MODE_W-1:0] mode_q,
  input  pio_timing_t       tim,
  input  logic              dev_ready,
  output pio_phase_e        phase,
  output logic [MODE_W-1:0] act_mode,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              acc_start,
  output logic              strobe_rel,
  output logic              cyc_end
);

  localparam logic [CNT_W-1:0] MIN_REC_C = CNT_W'(MIN_RECOV);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  logic [CNT_W-1:0] tot_q;
  logic [CNT_W-1:0] ph_q;
  logic [CNT_W-1:0] tot_inc;
  logic [CNT_W-1:0] ph_inc;

  assign tot_inc = (tot_q == CNT_MAX) ? tot_q : tot_q + 1'b1;
  assign ph_inc  = (ph_q  == CNT_MAX) ? ph_q  : ph_q  + 1'b1;

  assign acc_start  = (phase == PH_IDLE) && req_valid;
  assign strobe_rel = (phase == PH_STROBE) && (ph_q >= tim.strobe) && dev_ready;
  assign cyc_end    = (phase == PH_RECOV) && (tot_q >= tim.cycle) &&
                      (ph_q >= MIN_REC_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      tot_q    <= '0;
      ph_q     <= '0;
      act_mode <= '0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (acc_start) begin
            phase    <= PH_SETUP;
            tot_q    <= CNT_W'(1);
            ph_q     <= CNT_W'(1);
            act_mode <= mode_q;
            wr_q     <= req_write;
            addr_q   <= req_addr;
          end
        end
        PH_SETUP: begin
          tot_q <= tot_inc;
          if (ph_q >= tim.setup) begin
            phase <= PH_STROBE;
            ph_q  <= CNT_W'(1);
          end else begin
            ph_q <= ph_inc;
          end
        end
        PH_STROBE: begin
          tot_q <= tot_inc;
          if (strobe_rel) begin
            phase <= PH_RECOV;
            ph_q  <= CNT_W'(1);
          end else begin
            ph_q <= ph_inc;
          end
        end
        default: begin
          if (cyc_end) begin
            phase <= PH_IDLE;
            tot_q <= '0;
            ph_q  <= '0;
          end else begin
            tot_q <= tot_inc;
            ph_q  <= ph_inc;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pio_data_path.sv
module pio_data_path
  import pio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic              strobe_rel,
  input  pio_phase_e        phase,
  input  logic              wr_q,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dev_dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  logic [DATA_W-1:0] wdata_q;

  assign dq_out = wdata_q;
  assign dq_oe  = wr_q && ((phase == PH_SETUP) || (phase == PH_STROBE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      if (acc_start) wdata_q <= req_wdata;
      if (strobe_rel && !wr_q) rdata <= dev_dq_in;
      done <= strobe_rel;
    end
  end

endmodule

// File: rtl/pio_xfer_ctrl.sv
module pio_xfer_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int          ADDR_W        = 3,
  parameter int          DATA_W        = 16,
  parameter int unsigned SETUP_PCT     = 20,
  parameter int unsigned STROBE_PCT    = 50,
  parameter int          MIN_RECOV     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dev_rd_n,
  output logic              dev_wr_n,
  output logic [DATA_W-1:0] dev_dq_out,
  output logic              dev_dq_oe,
  input  logic [DATA_W-1:0] dev_dq_in,
  input  logic              dev_ready
);

  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] act_mode;
  pio_timing_t       tim;
  pio_phase_e        phase;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              acc_start;
  logic              strobe_rel;
  logic              cyc_end;

  pio_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_we  (mode_we),
    .mode_sel (mode_sel),
    .mode_q   (mode_q)
  );

  pio_timing_calc #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .SETUP_PCT     (SETUP_PCT),
    .STROBE_PCT    (STROBE_PCT)
  ) u_timing (
    .mode (act_mode),
    .tim  (tim)
  );

  pio_seq #(
    .ADDR_W    (ADDR_W),
    .MIN_RECOV (MIN_RECOV)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .mode_q     (mode_q),
    .tim        (tim),
    .dev_ready  (dev_ready),
    .phase      (phase),
    .act_mode   (act_mode),
    .wr_q       (wr_q),
    .addr_q     (addr_q),
    .acc_start  (acc_start),
    .strobe_rel (strobe_rel),
    .cyc_end    (cyc_end)
  );

  pio_data_path #(
    .DATA_W (DATA_W)
  ) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_start  (acc_start),
    .strobe_rel (strobe_rel),
    .phase      (phase),
    .wr_q       (wr_q),
    .req_wdata  (req_wdata),
    .dev_dq_in  (dev_dq_in),
    .dq_out     (dev_dq_out),
    .dq_oe      (dev_dq_oe),
    .rdata      (rdata),
    .done       (done)
  );

  assign busy     = (phase != PH_IDLE);
  assign dev_addr = addr_q;
  assign dev_rd_n = !((phase == PH_STROBE) && !wr_q);
  assign dev_wr_n = !((phase == PH_STROBE) && wr_q);

endmodule

// File: rtl/pio_xfer_ctrl_chk.sv
module pio_xfer_ctrl_chk
  import pio_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int          ADDR_W        = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              dev_rd_n,
  input logic              dev_wr_n,
  input logic              dev_dq_oe,
  input logic              dev_ready,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              acc_start,
  input logic              cyc_end,
  input logic [MODE_W-1:0] act_mode,
  input logic [MODE_W-1:0] mode_q
);

  localparam int unsigned MIN_CLKS = ns_to_clks(mode_cycle_ns(NUM_MODES - 1),
                                                CLK_PERIOD_PS);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 run_q <= '0;
    else if (busy && run_q != '1) run_q <= run_q + 1'b1;
    else if (!busy)             run_q <= '0;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_rd_n && !dev_wr_n)); // R3
  AST_MIN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q >= CNT_W'(MIN_CLKS))); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dev_addr)); // R3
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(act_mode)); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q < MODE_W'(NUM_MODES)); // R5
  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((!dev_rd_n || !dev_wr_n) && !dev_ready) |=> (!dev_rd_n || !dev_wr_n)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!(dev_rd_n && dev_wr_n)) && dev_rd_n && dev_wr_n)); // R7
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dev_dq_oe |-> (dev_rd_n && busy)); // R8
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> busy); // R9
  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !busy); // R9

endmodule

bind pio_xfer_ctrl pio_xfer_ctrl_chk #(
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .ADDR_W        (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .dev_rd_n  (dev_rd_n),
  .dev_wr_n  (dev_wr_n),
  .dev_dq_oe (dev_dq_oe),
  .dev_ready (dev_ready),
  .dev_addr  (dev_addr),
  .acc_start (acc_start),
  .cyc_end   (cyc_end),
  .act_mode  (act_mode),
  .mode_q    (mode_q)
);

// File: tb/test_pio_xfer_ctrl.sv
module test_pio_xfer_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, mode_we, dev_ready;
  logic [2:0]  req_addr, mode_sel, dev_addr;
  logic [15:0] req_wdata, rdata, dev_dq_out, dev_dq_in;
  logic        busy, done, dev_rd_n, dev_wr_n, dev_dq_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pio_xfer_ctrl i_pio_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .mode_we(mode_we),
    .mode_sel(mode_sel), .busy(busy), .done(done), .rdata(rdata),
    .dev_addr(dev_addr), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_dq_out(dev_dq_out), .dev_dq_oe(dev_dq_oe), .dev_dq_in(dev_dq_in),
    .dev_ready(dev_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected timing, restated from the requirement text
  function automatic int ceil_div(input int a, input int b);
    int q;
    q = a / b;
    if (a % b != 0) q = q + 1;
    return q;
  endfunction

  function automatic int exp_cycle(input int m);
    int ns;
    case (m)
      0: ns = 600;  1: ns = 383;  2: ns = 240;  3: ns = 180;
      4: ns = 120;  5: ns = 100;  default: ns = 80;
    endcase
    return ceil_div(ns * 1000, 4000);
  endfunction

  function automatic int exp_setup(input int m);
    return ceil_div(exp_cycle(m) * 20, 100);
  endfunction

  function automatic int exp_strobe(input int m);
    return ceil_div(exp_cycle(m) * 50, 100);
  endfunction

  task automatic set_mode(input int m);
    @(negedge clk);
    mode_we  = 1'b1;
    mode_sel = 3'(m);
    @(negedge clk);
    mode_we  = 1'b0;
    @(negedge clk);
  endtask

  // one access; checks timing, strobes, bus drive, done, read data
  task automatic do_access(input bit wr, input int addr, input int wd, input int pat,
                           input int mode_exp, input int stall, input int mid_mode,
                           input bit poke, input string tag);
    int p, sc, su, oe_cnt, dn, dn_at, bad_addr, bad_dq, bad_stb, t, s, w, wx, texp;
    int rd_at_done;
    s = exp_setup(mode_exp);
    w = exp_strobe(mode_exp);
    wx = (stall > 0) ? w + stall : w;
    texp = exp_cycle(mode_exp);
    if (s + wx + 1 > texp) texp = s + wx + 1;
    sc = 0; su = 0; oe_cnt = 0; dn = 0; dn_at = 0; bad_addr = 0; bad_dq = 0;
    bad_stb = 0; rd_at_done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 3'(addr);
    req_wdata = 16'(wd); dev_dq_in = 16'(pat); dev_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    p = 1;
    while (busy && p < 5000) begin
      if (mode_we) mode_we = 1'b0;
      if (req_valid) begin req_valid = 1'b0; req_addr = 3'(addr); end
      if ((wr && !dev_wr_n) || (!wr && !dev_rd_n)) sc++;
      else if (sc == 0) su++;
      if ((wr && !dev_rd_n) || (!wr && !dev_wr_n)) bad_stb++;
      if (dev_dq_oe) begin
        oe_cnt++;
        if (dev_dq_out != 16'(wd)) bad_dq++;
      end
      if (dev_addr != 3'(addr)) bad_addr++;
      if (done) begin dn++; dn_at = p; rd_at_done = int'(rdata); end
      if (stall > 0 && (!dev_rd_n || !dev_wr_n) && sc < wx) dev_ready = 1'b0;
      else dev_ready = 1'b1;
      if (p == 3 && mid_mode >= 0) begin mode_we = 1'b1; mode_sel = 3'(mid_mode); end
      if (p == 2 && poke) begin req_valid = 1'b1; req_addr = 3'(addr + 1); end
      @(negedge clk);
      p++;
    end
    dev_ready = 1'b1;
    t = p - 1;
    chk(t == texp, {"R3/R6 total length ", tag}, t, texp);
    chk(su == s, {"R3 setup length ", tag}, su, s);
    chk(sc == wx, {"R3/R6 strobe length ", tag}, sc, wx);
    chk(bad_stb == 0, {"R3 wrong strobe ", tag}, bad_stb, 0);
    chk(bad_addr == 0, {"R3 address stable ", tag}, bad_addr, 0);
    chk(dn == 1 && dn_at == s + wx + 1, {"R7 done pulse timing ", tag}, dn_at, s + wx + 1);
    chk(oe_cnt == (wr ? s + wx : 0), {"R8 bus drive length ", tag}, oe_cnt, wr ? s + wx : 0);
    chk(bad_dq == 0, {"R8 driven data ", tag}, bad_dq, 0);
    if (!wr) chk(rd_at_done == (pat & 16'hFFFF), {"R7 read data ", tag}, rd_at_done, pat & 16'hFFFF);
    // after the access: nothing further happens, read data holds
    dev_dq_in = ~16'(pat);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (busy || !dev_rd_n || !dev_wr_n) begin
        chk(0, {"R2 phantom access ", tag}, 1, 0);
        break;
      end
    end
    if (!wr) chk(rdata == 16'(pat), {"R7 read data held ", tag}, int'(rdata), pat & 16'hFFFF);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; mode_we = 1'b0; mode_sel = '0; dev_dq_in = '0; dev_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !dev_dq_oe && dev_rd_n && dev_wr_n, "R1 outputs in reset",
        {busy, done, dev_dq_oe, dev_rd_n, dev_wr_n}, 5'b00011);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !dev_dq_oe && dev_rd_n && dev_wr_n, "R1 outputs after reset",
        {busy, done, dev_dq_oe, dev_rd_n, dev_wr_n}, 5'b00011);

    // R1: default mode is the slowest one
    do_access(0, 1, 0, 16'hA5C3, 0, 0, -1, 0, "R1 read in reset mode");
    do_access(1, 6, 16'h1234, 0, 0, 0, -1, 0, "R8 write mode 0");

    // R3: every mode, reads and writes
    for (int m = 1; m < 7; m++) begin
      set_mode(m);
      do_access(0, m, 0, 16'h0F00 + m, m, 0, -1, 0, "R3 read per mode");
      do_access(1, 7 - m, 16'hBE00 + m, 0, m, 0, -1, 0, "R8 write per mode");
    end

    // R5: reserved value ignored
    set_mode(2);
    set_mode(7);
    do_access(0, 2, 0, 16'h5A5A, 2, 0, -1, 0, "R5 reserved mode ignored");

    // R4: mode write during a fast access
    set_mode(6);
    do_access(0, 3, 0, 16'h7777, 6, 0, 0, 0, "R4 current access keeps mode");
    do_access(0, 3, 0, 16'h8888, 0, 0, -1, 0, "R4 next access uses new mode");

    // R2/R9: request while busy is refused
    set_mode(4);
    do_access(1, 4, 16'hC0DE, 0, 4, 0, -1, 1, "R2 request while busy");

    // R6: ready stall beyond and within the minimum
    set_mode(6);
    do_access(0, 5, 0, 16'h3C3C, 6, 15, -1, 0, "R6 long stall");
    set_mode(0);
    do_access(1, 5, 16'h4242, 0, 0, 5, -1, 0, "R6 short stall");

    // R9: back-to-back, accepted as soon as busy is low
    set_mode(5);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd2;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 accepted right after busy low", int'(busy), 1);
    while (busy) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule